// File: doc/BRIEF.md
# Parallel Bitstream Loader

This block sits on the host side of a programmable target. It loads that target's configuration image over an eight-bit parallel link. A start request pulls the active-low configuration request line low for a fixed number of cycles. The block then waits for the target's active-low status line to come back high and lets a programmable settling time pass. After that it presents the image bytes on an eight-bit data bus together with a configuration clock that the host drives. The image arrives on a valid/ready byte stream whose final byte carries a last marker.

Two clocking modes are supported and the mode is chosen at start. In the plain mode each byte gets one configuration clock edge. In the quad mode each byte stays on the bus for four edges, which the target needs when it unpacks or deciphers the image itself. When the stream runs dry, the configuration clock is parked low and the next byte is on the bus before the next rising edge. When the target reports that loading is complete, the block issues a set number of extra clock edges. It then waits for the target's wake-up signal and, after a programmable delay, declares the target operational. A status drop while work is in progress, or a missing completion or wake-up signal, raises an error and returns the block to idle. A new start from the operational state begins a full reload.

Top module: `ppcfg_host`

## Requirements
- R1: While reset is asserted, cfg_req_n is 1, cfg_clk is 0, s_ready is 0, user_mode is 0 and err_flag is 0.
- R2: A start pulse is honoured only when the block is idle or operational. cfg_req_n is then held at 0 for exactly REQ_CYC clock cycles. A start pulse at any other time has no effect.
- R3: No rising cfg_clk edge and no s_ready occur until tgt_status_n has been sampled high and SETUP_CYC further cycles have elapsed. With a byte already waiting, the first rising edge follows the first high sample of tgt_status_n by SETUP_CYC+3 cycles.
- R4: quad_mode is captured at start and later changes have no effect on that load. quad_mode=0 gives exactly one rising cfg_clk edge per byte and quad_mode=1 gives exactly four, with cfg_data unchanged across all four. The bytes appear in stream order.
- R5: cfg_data is stable in the cycle before every rising cfg_clk edge.
- R6: cfg_clk stays low while no byte is available. s_ready is high only while cfg_clk is low and the previous byte's edges are complete, so one byte is accepted per slot.
- R7: After the byte flagged s_last has been clocked, no more bytes are taken. If tgt_loaded is not seen within TIMEOUT_CYC cycles, err_flag rises TIMEOUT_CYC+2 cycles after the last rising edge and the block returns to idle.
- R8: Once tgt_loaded is seen, exactly EXTRA_CLKS further rising edges are issued. cfg_clk is then held low for good, including in the operational state.
- R9: user_mode rises UM_CYC+1 cycles after tgt_awake first goes high.
- R10: A low tgt_status_n during loading or any later wait raises err_flag at once. No further edges are issued, s_ready is low and cfg_req_n is high.
- R11: A honoured start clears err_flag and user_mode within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a (re)load |
| quad_mode | input | 1 | 1 = four clock edges per byte, 0 = one |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of the image |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| cfg_req_n | output | 1 | Active-low configuration request to the target |
| tgt_status_n | input | 1 | Active-low target status |
| tgt_loaded | input | 1 | Target reports image fully received |
| tgt_awake | input | 1 | Target reports initialisation finished |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_data | output | 8 | Configuration data bus |
| user_mode | output | 1 | Target declared operational |
| err_flag | output | 1 | Last load failed |

## Verification
The bench sweeps both clocking modes, several image lengths and paced versus back-to-back streams. A design that clocked one edge per byte in quad mode, or that changed the byte between the four edges, would show a short byte count or a hold mismatch. A design that started clocking early after the status release, or that issued one extra edge or one too few after completion, would miss the exact cycle counts that the bench computes from the parameters. The error runs drop the status line part-way through an image and withhold the completion signal. A block that kept clocking, mistimed its timeout or failed to recover on the next start would show wrong byte counts, a wrong error cycle or a stale error flag.

// File: rtl/ppcfg_pkg.sv
package ppcfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_REQ   = 4'd1,
    ST_WSTAT = 4'd2,
    ST_SETUP = 4'd3,
    ST_LOAD  = 4'd4,
    ST_WDONE = 4'd5,
    ST_EXTRA = 4'd6,
    ST_WINIT = 4'd7,
    ST_UMW   = 4'd8,
    ST_USER  = 4'd9
  } ppcfg_state_e;

  // A phase of N cycles loads the down-counter with N-1 (minimum one cycle).
  function automatic int unsigned span_load(input int unsigned cycles);
    return (cycles == 0) ? 0 : cycles - 1;
  endfunction

  // Rising clock edges spent on one byte.
  function automatic logic [2:0] beats_per_byte(input logic quad);
    return quad ? 3'd4 : 3'd1;
  endfunction

endpackage

// File: rtl/ppcfg_timer.sv
module ppcfg_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ppcfg_dclk_gen.sv
module ppcfg_dclk_gen
  import ppcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_en,
  input  logic       free_en,
  input  logic       abort,
  input  logic       quad,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_clk,
  output logic [7:0] out_data,
  output logic       busy,
  output logic       fall_ev
);

  logic       hi_q;
  logic       loaded_q;
  logic [2:0] left_q;
  logic [7:0] byte_q;
  logic       take;

  // A new byte is taken only with the clock low and all edges of the
  // previous byte finished; it is on the bus one cycle before its first rise.
  assign in_ready = data_en && !loaded_q && !hi_q;
  assign take     = in_ready && in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= 1'b0;
      loaded_q <= 1'b0;
      left_q   <= '0;
      byte_q   <= '0;
    end else if (abort) begin
      hi_q     <= 1'b0;
      loaded_q <= 1'b0;
      left_q   <= '0;
    end else if (take) begin
      byte_q   <= in_data;
      loaded_q <= 1'b1;
      left_q   <= beats_per_byte(quad) - 3'd1;
    end else if (loaded_q) begin
      if (!hi_q) begin
        hi_q <= 1'b1;
      end else begin
        hi_q <= 1'b0;
        if (left_q == '0) loaded_q <= 1'b0;
        else              left_q   <= left_q - 3'd1;
      end
    end else if (free_en) begin
      hi_q <= ~hi_q;
    end else begin
      hi_q <= 1'b0;
    end
  end

  assign out_clk  = hi_q;
  assign out_data = byte_q;
  assign busy     = loaded_q || hi_q;
  assign fall_ev  = hi_q;

endmodule

// File: rtl/ppcfg_host.sv
module ppcfg_host
  import ppcfg_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned REQ_CYC     = 8,
  parameter int unsigned SETUP_CYC   = 8,
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter int unsigned EXTRA_CLKS  = 8,
  parameter int unsigned UM_CYC      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       quad_mode,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       s_ready,
  output logic       cfg_req_n,
  input  logic       tgt_status_n,
  input  logic       tgt_loaded,
  input  logic       tgt_awake,
  output logic       cfg_clk,
  output logic [7:0] cfg_data,
  output logic       user_mode,
  output logic       err_flag
);

  ppcfg_state_e st_q, st_d;
  logic         mode_q;
  logic         last_q;
  logic         err_q;

  // Named internal events.
  logic ev_start;
  logic ev_take;
  logic ev_err;
  logic ev_timeout;
  logic ev_stat_drop;
  logic ev_load_end;
  logic in_watch;

  logic             t_zero;
  logic             t_load;
  logic             t_dec;
  logic [CNT_W-1:0] t_val;

  logic g_ready;
  logic g_busy;
  logic g_fall;
  logic g_data_en;
  logic g_free_en;

  assign ev_start     = start && ((st_q == ST_IDLE) || (st_q == ST_USER));
  assign in_watch     = st_q inside {ST_LOAD, ST_WDONE, ST_EXTRA, ST_WINIT, ST_UMW};
  assign ev_stat_drop = in_watch && !tgt_status_n;
  assign ev_timeout   = t_zero && (((st_q == ST_WDONE) && !tgt_loaded) ||
                                   ((st_q == ST_WINIT) && !tgt_awake));
  assign ev_err       = ev_stat_drop || ev_timeout;
  assign ev_take      = s_valid && g_ready;
  assign ev_load_end  = (st_q == ST_LOAD) && last_q && !g_busy;

  always_comb begin
    st_d = st_q;
    if (ev_err) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE, ST_USER: if (start)        st_d = ST_REQ;
        ST_REQ:           if (t_zero)       st_d = ST_WSTAT;
        ST_WSTAT:         if (tgt_status_n) st_d = ST_SETUP;
        ST_SETUP:         if (t_zero)       st_d = ST_LOAD;
        ST_LOAD:          if (ev_load_end)  st_d = ST_WDONE;
        ST_WDONE:         if (tgt_loaded)   st_d = ST_EXTRA;
        ST_EXTRA:         if (t_zero && !cfg_clk) st_d = ST_WINIT;
        ST_WINIT:         if (tgt_awake)    st_d = ST_UMW;
        ST_UMW:           if (t_zero)       st_d = ST_USER;
        default:                            st_d = ST_IDLE;
      endcase
    end
  end

  // One shared down-counter, reloaded on every state change.
  always_comb begin
    case (st_d)
      ST_REQ:             t_val = CNT_W'(span_load(REQ_CYC));
      ST_SETUP:           t_val = CNT_W'(span_load(SETUP_CYC));
      ST_WDONE, ST_WINIT: t_val = CNT_W'(span_load(TIMEOUT_CYC));
      ST_EXTRA:           t_val = CNT_W'(EXTRA_CLKS);
      ST_UMW:             t_val = CNT_W'(span_load(UM_CYC));
      default:            t_val = '0;
    endcase
  end

  assign t_load = (st_d != st_q);
  assign t_dec  = (st_q == ST_EXTRA) ? g_fall : 1'b1;

  ppcfg_timer #(.W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .dec      (t_dec),
    .zero     (t_zero)
  );

  assign g_data_en = (st_q == ST_LOAD) && !last_q;
  assign g_free_en = (st_q == ST_EXTRA) && !t_zero;

  ppcfg_dclk_gen gen_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_en  (g_data_en),
    .free_en  (g_free_en),
    .abort    (ev_err),
    .quad     (mode_q),
    .in_valid (s_valid),
    .in_data  (s_data),
    .in_ready (g_ready),
    .out_clk  (cfg_clk),
    .out_data (cfg_data),
    .busy     (g_busy),
    .fall_ev  (g_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ev_start) begin
        mode_q <= quad_mode;
        last_q <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        if (ev_take && s_last) last_q <= 1'b1;
        if (ev_err)            err_q  <= 1'b1;
      end
    end
  end

  assign s_ready   = g_ready;
  assign cfg_req_n = (st_q != ST_REQ);
  assign user_mode = (st_q == ST_USER);
  assign err_flag  = err_q;

endmodule

// File: rtl/ppcfg_host_chk.sv
module ppcfg_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_req_n,
  input logic       cfg_clk,
  input logic [7:0] cfg_data,
  input logic       s_ready,
  input logic       tgt_status_n,
  input logic       user_mode,
  input logic       err_flag,
  input logic       mode_q,
  input logic       ev_take
);

  logic       clk_d;
  logic [3:0] rises;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d <= 1'b0;
      rises <= '0;
      seen  <= 1'b0;
    end else begin
      clk_d <= cfg_clk;
      if (!cfg_req_n) begin
        seen  <= 1'b0;
        rises <= '0;
      end else if (ev_take) begin
        seen  <= 1'b1;
        rises <= '0;
      end else if (cfg_clk && !clk_d && (rises != 4'hF)) begin
        rises <= rises + 4'd1;
      end
    end
  end

  a_r2_req_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req_n |-> (!cfg_clk && !s_ready));

  a_r3_rise_after_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> $past(tgt_status_n));

  a_r4_beats: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && seen) |-> (rises == (mode_q ? 4'd4 : 4'd1)));

  a_r5_data_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> $stable(cfg_data));

  a_r6_ready_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !cfg_clk);

  a_r8_parked: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode |-> !cfg_clk);

  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (cfg_req_n && !cfg_clk && !user_mode));

endmodule

bind ppcfg_host ppcfg_host_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_req_n    (cfg_req_n),
  .cfg_clk      (cfg_clk),
  .cfg_data     (cfg_data),
  .s_ready      (s_ready),
  .tgt_status_n (tgt_status_n),
  .user_mode    (user_mode),
  .err_flag     (err_flag),
  .mode_q       (mode_q),
  .ev_take      (ev_take)
);

// File: tb/ppcfg_host_tb.sv
`timescale 1ns/100ps
module ppcfg_host_tb_top;

  localparam int REQ_CYC     = 3;
  localparam int SETUP_CYC   = 4;
  localparam int TIMEOUT_CYC = 40;
  localparam int EXTRA_CLKS  = 5;
  localparam int UM_CYC      = 6;
  localparam int ST_DLY      = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       quad_mode = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic       cfg_req_n;
  logic       tgt_status_n = 1'b0;
  logic       tgt_loaded = 1'b0;
  logic       tgt_awake = 1'b0;
  logic       cfg_clk;
  logic [7:0] cfg_data;
  logic       user_mode;
  logic       err_flag;

  always #2.5 clk = ~clk;

  ppcfg_host #(
    .CNT_W(8), .REQ_CYC(REQ_CYC), .SETUP_CYC(SETUP_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC), .EXTRA_CLKS(EXTRA_CLKS), .UM_CYC(UM_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .quad_mode(quad_mode),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .cfg_req_n(cfg_req_n), .tgt_status_n(tgt_status_n),
    .tgt_loaded(tgt_loaded), .tgt_awake(tgt_awake),
    .cfg_clk(cfg_clk), .cfg_data(cfg_data),
    .user_mode(user_mode), .err_flag(err_flag)
  );

  int total = 0;
  int bad = 0;

  // Target model state
  int cyc = 0;
  int per = 1, exp_n = 0, no_done = 0, drop_at = -1;
  int got = 0, sub = 0, dly = 0, extra = 0, done_cnt = 0, dropped = 0;
  int req_low = 0, stat_rise = 0, first_rise = -1, last_rise = 0, err_cyc = -1;
  int setup_bad = 0, hold_bad = 0, um_cnt = 0, um_at = 0, um_done = 0;
  logic       prev_clk = 1'b0;
  logic [7:0] prev_data = '0;
  logic [7:0] cap [16];
  logic [7:0] exp_data [16];

  task automatic chk(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  // Target model: samples at the falling edge, away from the active edge.
  always @(negedge clk) begin
    logic rise;
    cyc++;
    rise = cfg_clk && !prev_clk;
    prev_clk = cfg_clk;
    if (!cfg_req_n) begin
      req_low++;
      tgt_status_n = 1'b0; tgt_loaded = 1'b0; tgt_awake = 1'b0;
      got = 0; sub = 0; dly = 0; extra = 0; done_cnt = 0; dropped = 0;
      first_rise = -1; err_cyc = -1; um_cnt = 0; um_done = 0; um_at = 0;
      setup_bad = 0; hold_bad = 0;
    end else begin
      if (!tgt_status_n && !dropped) begin
        dly++;
        if (dly == ST_DLY) begin tgt_status_n = 1'b1; stat_rise = cyc; end
      end
      if (rise && !tgt_loaded) begin
        if (cfg_data != prev_data) setup_bad++;
        if (first_rise < 0) first_rise = cyc;
        last_rise = cyc;
        if (sub == 0) begin
          if (got < 16) cap[got] = cfg_data;
        end else if (got < 16 && cfg_data != cap[got]) begin
          hold_bad++;
        end
        sub++;
        if (sub == per) begin
          sub = 0; got++;
          if (got == drop_at) begin tgt_status_n = 1'b0; dropped = 1; end
        end
      end else if (rise) begin
        extra++;
      end
      if (err_flag && err_cyc < 0) err_cyc = cyc;
      if (tgt_awake && !um_done) begin
        um_cnt++;
        if (user_mode) begin um_done = 1; um_at = um_cnt; end
      end
      if (tgt_loaded) begin
        done_cnt++;
        if (done_cnt == 2 * EXTRA_CLKS + 10) tgt_awake = 1'b1;
      end else if (exp_n > 0 && got == exp_n && sub == 0 && !no_done && tgt_status_n) begin
        tgt_loaded = 1'b1;
      end
    end
    prev_data = cfg_data;
  end

  task automatic wait_cycles(input int n);
    for (int k = 0; k < n; k++) begin @(negedge clk); #1; end
  endtask

  task automatic run_cfg(input int mode, input int n, input int gap, input int nd, input int dat);
    int mm;
    per = mode ? 4 : 1; exp_n = n; no_done = nd; drop_at = dat; req_low = 0;
    for (int i = 0; i < n; i++) exp_data[i] = 8'((i * 53 + n * 7 + mode * 29 + gap + 1) & 255);
    @(negedge clk);
    quad_mode = mode[0]; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0; quad_mode = ~mode[0];      // later mode changes must not matter (R4)
    chk("R11 err cleared on start", int'(err_flag), 0);
    chk("R11 user_mode cleared on start", int'(user_mode), 0);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1; s_data = exp_data[i]; s_last = (i == n - 1);
      if (i == 1) start = 1'b1;              // must be ignored (R2)
      while (!s_ready && !err_flag) begin @(negedge clk); start = 1'b0; #1; end
      @(negedge clk);
      start = 1'b0; s_valid = 1'b0; s_last = 1'b0;
      #1;
      if (err_flag) break;
      if (gap > 0) begin
        wait_cycles(gap);
        if (i != n - 1) begin
          chk("R6 clock parked while starved", int'(cfg_clk), 0);
          chk("R6 ready offered while starved", int'(s_ready), 1);
        end
      end
    end
    if (nd != 0) begin
      while (!err_flag) begin @(negedge clk); #1; end
      chk("R7 timeout cycle", err_cyc - last_rise, TIMEOUT_CYC + 2);
      chk("R7 byte count before timeout", got, n);
      chk("R7 idle after timeout", int'({cfg_req_n, cfg_clk, user_mode}), 4);
    end else if (dat >= 0) begin
      while (!err_flag) begin @(negedge clk); #1; end
      wait_cycles(10);
      chk("R10 no edges after status drop", got * 4 + sub, dat * 4);
      chk("R10 quiet outputs after drop", int'({cfg_req_n, cfg_clk, s_ready, user_mode}), 8);
    end else begin
      while (!user_mode) begin @(negedge clk); #1; end
      chk("R2 request width", req_low, REQ_CYC);
      chk("R3 first edge delay", first_rise - stat_rise, SETUP_CYC + 3);
      chk("R4 bytes clocked", got, n);
      chk("R4 byte held over edges", hold_bad, 0);
      mm = 0;
      for (int i = 0; i < n; i++) if (cap[i] != exp_data[i]) mm++;
      chk("R4 byte order and value", mm, 0);
      chk("R5 data settled before edge", setup_bad, 0);
      chk("R9 user mode delay", um_at, UM_CYC + 1);
      wait_cycles(6);
      chk("R8 extra edges after completion", extra, EXTRA_CLKS);
      chk("R8 clock parked in user mode", int'(cfg_clk), 0);
      chk("R7 no bytes taken after last", int'(s_ready), 0);
    end
  endtask

  initial begin
    wait_cycles(4);
    chk("R1 request high in reset", int'(cfg_req_n), 1);
    chk("R1 clock low in reset", int'(cfg_clk), 0);
    chk("R1 ready low in reset", int'(s_ready), 0);
    chk("R1 flags low in reset", int'({user_mode, err_flag}), 0);
    rst_n = 1'b1;
    wait_cycles(2);
    for (int m = 0; m < 2; m++)
      for (int g = 0; g < 2; g++)
        for (int ni = 0; ni < 3; ni++)
          run_cfg(m, (ni == 0) ? 1 : ((ni == 1) ? 3 : 6), g * 12, 0, -1);
    run_cfg(0, 2, 0, 1, -1);   // R7 timeout
    run_cfg(0, 3, 0, 0, -1);   // R11 recovery
    run_cfg(1, 5, 0, 0, 2);    // R10 status drop in quad mode
    run_cfg(1, 4, 0, 0, -1);   // R11 recovery
    run_cfg(0, 5, 0, 0, 3);    // R10 status drop in plain mode
    run_cfg(0, 2, 12, 0, -1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all requirements) act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule